// File: doc/BRIEF.md
# Three-phase waveform sample sequencer

This block produces signed amplitude samples for the three phases of a power waveform. A fractional phase accumulator steps around a 1536-position full cycle at a rate set by a 12-bit frequency word and a 3-bit range code. Only the first half cycle (positions 0 to 767) is stored, in an external ROM of 4-bit words. The 8-bit sample for each position is split into two nibbles, and the top address line selects which nibble area is read. The block fetches both nibbles for each phase, joins them and gives the second half cycle a negative sign. It then scales each magnitude by a 9-bit gain, made of an overmodulation bit above an 8-bit amplitude word, and presents the red, yellow and blue values together on a valid/ready stream.

The ROM read is combinational: `rom_nibble` must reflect `rom_addr` within the same clock cycle. After reset, and after each accepted set, the block performs six reads (red, yellow, blue; low nibble before high nibble). It takes one scaling cycle and then raises `out_valid`. A consumer that holds `out_ready` low stalls the block. The presented values, `out_valid` and the phase position all stay frozen until the cycle in which `out_valid` and `out_ready` are both high. That accepting edge advances the phase and starts the next fetch. The accepted-set rate is the sample rate that the frequency formulas refer to. A zero-phase marker, derived from the red position, runs at the power frequency.

Top module: `tri_wave_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the cycle it is released, `out_valid` is low and the accumulator is zero. The first set presented after reset is for red position 0.
- R2: The low nibble of half-cycle sample i (0..767) is read at address i, and the high nibble at address 1024+i (address bit 10 set). Bits 9..0 of `rom_addr` never exceed 767.
- R3: Each set takes exactly six consecutive reads, starting in the cycle after the accepting edge (or after reset release), in the order red-low, red-high, yellow-low, yellow-high, blue-low, blue-high. The sample is {high nibble, low nibble}.
- R4: Each accepted set changes the accumulator by `freq_word << s`, where s is `range_code`, capped at 6 (codes 6 and 7 both give 64). The accumulator counts in 1/1024 of a position, modulo 1536*1024, and the red position is the accumulator divided by 1024.
- R5: With `reverse` high, the accumulator decreases by the same step, wrapping below zero. A direction change continues from the current position with no jump.
- R6: Yellow is at red+512 and blue at red+1024, modulo 1536. A position p of 768 or more uses stored sample p-768 with a negative sign.
- R7: While `spin_en` is low, each accepted set puts the accumulator to zero and the frequency word has no effect. All sets then show red position 0.
- R8: The output magnitude is floor(sample*G/255) with G = `overmod`*256 + `amp`, saturated at 255. Each value is 9-bit two's complement.
- R9: `zero_mark` is high exactly when the red position is 1024 or more. It falls at 0 degrees when counting forward and rises there when counting in reverse.
- R10: Once `out_valid` is high it stays high, and the three values stay unchanged, until accepted. Without acceptance the phase does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_word | input | 12 | Power-frequency step within the selected range |
| range_code | input | 3 | Range multiplier exponent (0..6, 7 treated as 6) |
| reverse | input | 1 | 1 = phase counts down (reverse rotation) |
| spin_en | input | 1 | 0 = phase held at zero (DC braking) |
| amp | input | 8 | Amplitude word, full scale 255 |
| overmod | input | 1 | Ninth, most significant gain bit |
| rom_addr | output | 11 | Waveform ROM address, bit 10 selects the high-nibble area |
| rom_nibble | input | 4 | ROM data for the current address |
| out_valid | output | 1 | Sample set available |
| out_ready | input | 1 | Consumer accepts the set |
| red_val | output | 9 | Signed red-phase sample |
| yel_val | output | 9 | Signed yellow-phase sample |
| blu_val | output | 9 | Signed blue-phase sample |
| zero_mark | output | 1 | Zero-phase marker, high for the last third of the red cycle |

## Verification
A corrupted accumulator shows up in the next presented set, and in the address sequence of the fetch that follows an acceptance: within seven cycles every phase value and the marker no longer match the position the step model predicts. A wrong nibble order, or a wrong area select, gives wrong values for all three phases in the same set. Sign or offset errors show up once the position moves into the second half cycle or past 512. A stream that moves while stalled changes the values during the hold window.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  localparam int HALF_LEN = 768;
  localparam int FULL_LEN = 2 * HALF_LEN;
  localparam int THIRD    = FULL_LEN / 3;
  localparam int IDX_W    = $clog2(FULL_LEN);
  localparam int SIDX_W   = $clog2(HALF_LEN);
  localparam int ADDR_W   = SIDX_W + 1;
  localparam int NIB_W    = 4;
  localparam int SAMP_W   = 2 * NIB_W;
  localparam int OUT_W    = SAMP_W + 1;
  localparam int NPHASE   = 3;
  localparam int NSTEP    = 2 * NPHASE;
  localparam int STEP_W   = $clog2(NSTEP);

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_SCALE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/wsq_phase_accum.sv
module wsq_phase_accum
  import wsq_pkg::*;
#(
  parameter int FREQ_W    = 12,
  parameter int FRAC_W    = 10,
  parameter int RANGE_W   = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               spin_en,
  input  logic               reverse,
  input  logic [FREQ_W-1:0]  freq_word,
  input  logic [RANGE_W-1:0] range_code,
  output logic [IDX_W-1:0]   red_pos
);
  localparam int ACC_W = IDX_W + FRAC_W;
  localparam logic [ACC_W:0] ACC_MOD = (ACC_W+1)'(FULL_LEN) << FRAC_W;

  logic [ACC_W-1:0]   acc_q;
  logic [ACC_W:0]     acc_x, step, up_raw, up_sum, dn_sum, nxt;
  logic [RANGE_W-1:0] shift;

  always_comb begin
    shift  = (range_code > RANGE_W'(MAX_SHIFT)) ? RANGE_W'(MAX_SHIFT) : range_code;
    step   = (ACC_W+1)'(freq_word) << shift;
    acc_x  = {1'b0, acc_q};
    up_raw = acc_x + step;
    up_sum = (up_raw >= ACC_MOD) ? up_raw - ACC_MOD : up_raw;
    dn_sum = (acc_x >= step) ? acc_x - step : acc_x + ACC_MOD - step;
    nxt    = reverse ? dn_sum : up_sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (advance) begin
      acc_q <= spin_en ? ACC_W'(nxt) : '0;
    end
  end

  assign red_pos = acc_q[ACC_W-1:FRAC_W];

  assert_acc_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, acc_q} < ACC_MOD);

  assert_brake_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !spin_en) |=> (acc_q == '0));

  assert_idle_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(acc_q));
endmodule

// File: rtl/wsq_fetch.sv
module wsq_fetch
  import wsq_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             launch,
  input  logic [IDX_W-1:0]                 red_pos,
  input  logic [NIB_W-1:0]                 rom_nibble,
  output logic [ADDR_W-1:0]                rom_addr,
  output logic [NPHASE-1:0][SAMP_W-1:0]    samp,
  output logic [NPHASE-1:0]                neg,
  output logic                             scale_now
);
  localparam int PH_W = STEP_W - 1;

  seq_state_e                     st_q;
  logic [STEP_W-1:0]              step_q;
  logic [NSTEP-1:0][NIB_W-1:0]    nib_q;
  logic [SIDX_W-1:0]              sidx [NPHASE];
  logic [SIDX_W-1:0]              cur_sidx;
  logic [PH_W-1:0]                ph;

  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    logic [IDX_W:0]   raw;
    logic [IDX_W-1:0] pos;
    assign raw     = {1'b0, red_pos} + (IDX_W+1)'(p * THIRD);
    assign pos     = IDX_W'((raw >= (IDX_W+1)'(FULL_LEN)) ? raw - (IDX_W+1)'(FULL_LEN) : raw);
    assign neg[p]  = (pos >= IDX_W'(HALF_LEN));
    assign sidx[p] = SIDX_W'(neg[p] ? pos - IDX_W'(HALF_LEN) : pos);
    assign samp[p] = {nib_q[2*p+1], nib_q[2*p]};
  end

  assign ph = step_q[STEP_W-1:1];

  always_comb begin
    cur_sidx = '0;
    for (int p = 0; p < NPHASE; p++) begin
      if (ph == PH_W'(p)) cur_sidx = sidx[p];
    end
  end

  assign rom_addr  = {step_q[0], cur_sidx};
  assign scale_now = (st_q == ST_SCALE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_FETCH;
      step_q <= '0;
      nib_q  <= '0;
    end else begin
      unique case (st_q)
        ST_FETCH: begin
          nib_q[step_q] <= rom_nibble;
          if (step_q == STEP_W'(NSTEP - 1)) begin
            step_q <= '0;
            st_q   <= ST_SCALE;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_SCALE: st_q <= ST_WAIT;
        ST_WAIT:  if (launch) st_q <= ST_FETCH;
        default:  st_q <= ST_FETCH;
      endcase
    end
  end

  assert_addr_in_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[SIDX_W-1:0] < SIDX_W'(HALF_LEN));

  assert_nibble_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH && !step_q[0]) |=>
      (rom_addr[ADDR_W-1] && rom_addr[SIDX_W-1:0] == $past(rom_addr[SIDX_W-1:0])));
endmodule

// File: rtl/wsq_amp_scale.sv
module wsq_amp_scale #(
  parameter int SAMP_W   = 8,
  parameter int AMP_W    = 8,
  parameter int RECIP_SH = 25
) (
  input  logic [SAMP_W-1:0]        samp,
  input  logic [AMP_W:0]           gain,
  input  logic                     neg,
  output logic signed [SAMP_W:0]   value
);
  localparam int     PROD_W = SAMP_W + AMP_W + 1;
  localparam int     WIDE_W = PROD_W + RECIP_SH;
  localparam longint DENOM  = (longint'(1) << AMP_W) - 1;
  localparam longint RECIP  = ((longint'(1) << RECIP_SH) + DENOM - 1) / DENOM;
  localparam logic [SAMP_W-1:0] FULL = '1;

  logic [PROD_W-1:0] prod;
  logic [WIDE_W-1:0] wide, quot;
  logic [SAMP_W-1:0] mag;

  always_comb begin
    prod  = PROD_W'(samp) * PROD_W'(gain);
    wide  = WIDE_W'(prod) * WIDE_W'(RECIP);
    quot  = wide >> RECIP_SH;
    mag   = (quot > WIDE_W'(FULL)) ? FULL : quot[SAMP_W-1:0];
    value = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/tri_wave_sequencer.sv
module tri_wave_sequencer
  import wsq_pkg::*;
#(
  parameter int FREQ_W  = 12,
  parameter int FRAC_W  = 10,
  parameter int RANGE_W = 3,
  parameter int AMP_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [FREQ_W-1:0]        freq_word,
  input  logic [RANGE_W-1:0]       range_code,
  input  logic                     reverse,
  input  logic                     spin_en,
  input  logic [AMP_W-1:0]         amp,
  input  logic                     overmod,
  output logic [ADDR_W-1:0]        rom_addr,
  input  logic [NIB_W-1:0]         rom_nibble,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  red_val,
  output logic signed [OUT_W-1:0]  yel_val,
  output logic signed [OUT_W-1:0]  blu_val,
  output logic                     zero_mark
);
  logic                            accept;
  logic [IDX_W-1:0]                red_pos;
  logic [NPHASE-1:0][SAMP_W-1:0]   samp;
  logic [NPHASE-1:0]               neg;
  logic                            scale_now;
  logic signed [OUT_W-1:0]         scaled [NPHASE];
  logic signed [OUT_W-1:0]         val_q  [NPHASE];

  assign accept = out_valid && out_ready;

  wsq_phase_accum #(
    .FREQ_W(FREQ_W), .FRAC_W(FRAC_W), .RANGE_W(RANGE_W), .MAX_SHIFT(6)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .advance(accept), .spin_en(spin_en),
    .reverse(reverse), .freq_word(freq_word), .range_code(range_code),
    .red_pos(red_pos)
  );

  wsq_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .launch(accept), .red_pos(red_pos),
    .rom_nibble(rom_nibble), .rom_addr(rom_addr), .samp(samp), .neg(neg),
    .scale_now(scale_now)
  );

  for (genvar p = 0; p < NPHASE; p++) begin : g_scale
    wsq_amp_scale #(.SAMP_W(SAMP_W), .AMP_W(AMP_W), .RECIP_SH(25)) u_scale (
      .samp(samp[p]), .gain({overmod, amp}), .neg(neg[p]), .value(scaled[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      for (int p = 0; p < NPHASE; p++) val_q[p] <= '0;
    end else if (scale_now) begin
      out_valid <= 1'b1;
      for (int p = 0; p < NPHASE; p++) val_q[p] <= scaled[p];
    end else if (accept) begin
      out_valid <= 1'b0;
    end
  end

  assign red_val   = val_q[0];
  assign yel_val   = val_q[1];
  assign blu_val   = val_q[2];
  assign zero_mark = (red_pos >= IDX_W'(2 * THIRD));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(red_val) && $stable(yel_val) && $stable(blu_val)));
endmodule

// File: tb/tri_wave_sequencer_bench.sv
module tri_wave_sequencer_bench;
  localparam int MOD = 1536 * 1024;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic [11:0]        freq_word;
  logic [2:0]         range_code;
  logic               reverse, spin_en, overmod, out_ready;
  logic [7:0]         amp;
  logic [10:0]        rom_addr;
  logic [3:0]         rom_nibble;
  logic               out_valid, zero_mark;
  logic signed [8:0]  red_val, yel_val, blu_val;

  int checks = 0;
  int errors = 0;
  int acc_e  = 0;

  tri_wave_sequencer u_tri_wave_sequencer (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .range_code(range_code),
    .reverse(reverse), .spin_en(spin_en), .amp(amp), .overmod(overmod),
    .rom_addr(rom_addr), .rom_nibble(rom_nibble), .out_valid(out_valid),
    .out_ready(out_ready), .red_val(red_val), .yel_val(yel_val),
    .blu_val(blu_val), .zero_mark(zero_mark)
  );

  function automatic int samp_of(int i);
    return (i * 37 + 11) % 256;
  endfunction

  function automatic logic [3:0] rom_read(logic [10:0] a);
    int s;
    s = (int'(a[9:0]) < 768) ? samp_of(int'(a[9:0])) : 0;
    return a[10] ? 4'(s / 16) : 4'(s % 16);
  endfunction

  assign rom_nibble = rom_read(rom_addr);

  function automatic int exp_val(int red, int p);
    int pos, i, m, g;
    pos = (red + 512 * p) % 1536;
    i   = (pos >= 768) ? pos - 768 : pos;
    g   = (overmod ? 256 : 0) + int'(amp);
    m   = samp_of(i) * g / 255;
    if (m > 255) m = 255;
    return (pos >= 768) ? -m : m;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_valid(string req);
    int n = 0;
    while (!out_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(req, "out_valid arrives", int'(out_valid), 1);
  endtask

  task automatic check_set(string req);
    int red;
    red = acc_e / 1024;
    chk(req, "red_val", int'(red_val), exp_val(red, 0));
    chk(req, "yel_val", int'(yel_val), exp_val(red, 1));
    chk(req, "blu_val", int'(blu_val), exp_val(red, 2));
    chk("R9", "zero_mark", int'(zero_mark), (red >= 1024) ? 1 : 0);
  endtask

  // accepting edge; returns at the negedge that follows it
  task automatic accept_set();
    int inc, sh;
    out_ready = 1'b1;
    sh  = (range_code > 3'd6) ? 6 : int'(range_code);
    inc = int'(freq_word) << sh;
    if (!spin_en)     acc_e = 0;
    else if (reverse) acc_e = (acc_e - inc + MOD) % MOD;
    else              acc_e = (acc_e + inc) % MOD;
    @(posedge clk);
    #1 out_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_addr(string req);
    int red, pos, i;
    red = acc_e / 1024;
    for (int k = 0; k < 6; k++) begin
      pos = (red + 512 * (k / 2)) % 1536;
      i   = (pos >= 768) ? pos - 768 : pos;
      chk(req, "rom_addr", int'(rom_addr), (k % 2 == 1) ? 1024 + i : i);
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; freq_word = '0; range_code = '0; reverse = 1'b0;
    spin_en = 1'b1; amp = 8'd255; overmod = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R9", "zero_mark in reset", int'(zero_mark), 0);
    rst_n = 1'b1;
    chk("R1", "out_valid at release", int'(out_valid), 0);
    check_addr("R1");
    wait_valid("R1");
    check_set("R1");
  endtask

  task automatic test_fetch_order();
    freq_word = 12'd300; range_code = 3'd2;
    accept_set();
    check_addr("R2");
    wait_valid("R2");
    check_set("R3");
    freq_word = 12'd4000; range_code = 3'd5;
    accept_set();
    check_addr("R3");
    wait_valid("R3");
    check_set("R6");
  endtask

  task automatic test_forward();
    freq_word = 12'd4095; range_code = 3'd6;
    for (int n = 0; n < 8; n++) begin
      accept_set();
      wait_valid("R4");
      check_set("R6");
    end
    range_code = 3'd7;
    accept_set();
    wait_valid("R4");
    check_set("R4");
  endtask

  task automatic test_reverse();
    reverse = 1'b1; freq_word = 12'd2000; range_code = 3'd6;
    for (int n = 0; n < 9; n++) begin
      accept_set();
      check_addr("R5");
      wait_valid("R5");
      check_set("R5");
    end
    reverse = 1'b0;
  endtask

  task automatic test_backpressure();
    logic signed [8:0] r, y, b;
    logic z;
    freq_word = 12'd777; range_code = 3'd3;
    accept_set();
    wait_valid("R10");
    r = red_val; y = yel_val; b = blu_val; z = zero_mark;
    freq_word = 12'd4095;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      chk("R10", "valid held", int'(out_valid), 1);
      chk("R10", "red held", int'(red_val), int'(r));
      chk("R10", "yel held", int'(yel_val), int'(y));
      chk("R10", "blu held", int'(blu_val), int'(b));
      chk("R10", "marker held", int'(zero_mark), int'(z));
    end
    check_set("R10");
  endtask

  task automatic test_amplitude();
    freq_word = 12'd1500; range_code = 3'd4;
    amp = 8'd128; overmod = 1'b0;
    accept_set(); wait_valid("R8"); check_set("R8");
    amp = 8'd255; overmod = 1'b1;
    accept_set(); wait_valid("R8"); check_set("R8");
    amp = 8'd0; overmod = 1'b1;
    accept_set(); wait_valid("R8"); check_set("R8");
    amp = 8'd0; overmod = 1'b0;
    accept_set(); wait_valid("R8"); check_set("R8");
    amp = 8'd255;
  endtask

  task automatic test_brake();
    spin_en = 1'b0; freq_word = 12'd4095; range_code = 3'd6;
    for (int n = 0; n < 2; n++) begin
      accept_set();
      check_addr("R7");
      wait_valid("R7");
      check_set("R7");
      chk("R7", "held at zero", acc_e, 0);
    end
    spin_en = 1'b1;
    accept_set(); wait_valid("R7"); check_set("R7");
  endtask

  initial begin
    test_reset();
    test_fetch_order();
    test_forward();
    test_reverse();
    test_backpressure();
    test_amplitude();
    test_brake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule